// File: doc/BRIEF.md
# Wake Event Detector

This block watches a group of asynchronous wake sources and decides, channel by channel, whether a wake condition has occurred. Each channel senses a low level, a high level, a falling edge or a rising edge. Two control bits select the mode. A polarity bit picks which input value counts as active. An edge-select bit picks level sensing or transition sensing.

A hit sets a sticky status bit for the channel. Software clears status bits by writing ones. A per-channel enable decides whether a set status bit drives the single combined wake output.

Every input passes through a two-stage synchronizer before it reaches the detector. Channels exist only at fixed bit positions. All other positions, including a reserved slot, have no detector, and their control bits read as zero.

Top module: `wev_detect`

## Requirements
- R1: With polarity bit 0 and edge-select bit 0, a channel sets its status while its synchronized input is low. Polarity is written with wr_sel=0 and edge-select with wr_sel=1, and data bit i belongs to channel i.
- R2: With polarity bit 1 and edge-select bit 0, a channel sets its status while its synchronized input is high.
- R3: With polarity bit 0 and edge-select bit 1, a channel sets its status on a falling transition of its input and ignores a rising one.
- R4: With polarity bit 1 and edge-select bit 1, a channel sets its status on a rising transition of its input and ignores a falling one.
- R5: Reset clears the polarity, edge-select and enable registers (enable is written with wr_sel=2), clears all status bits and deasserts wake_event.
- R6: Only positions 4 to 10 and 12 hold detectors under the default mask 16'h17F0. Position 11 and every other position never set status, and their control bits read back as 0 on rd_data for any rd_sel.
- R7: A change on an input reaches status at the third rising clock edge after the change and not earlier.
- R8: wake_event is high exactly when some channel has both its status and its enable bit set. Status still latches on a disabled channel.
- R9: In edge mode a status bit stays set until a 1 is written to its clr_mask bit with clr_en high. In level mode a clear does not take hold while the active level persists.
- R10: When a clear and a new detection fall in the same cycle, the status bit ends up set.
- R11: In the cycle right after a write changes a channel's polarity or edge-select bit, edge detection on that channel is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wake_in | input | CH_W | Asynchronous wake sources, one per bit position |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 polarity, 1 edge-select, 2 enable |
| wr_data | input | CH_W | Register write data |
| rd_sel | input | 2 | Readback select, same encoding as wr_sel |
| rd_data | output | CH_W | Selected register contents |
| clr_en | input | 1 | Status clear strobe |
| clr_mask | input | CH_W | Bits written 1 clear the matching status bits |
| status | output | CH_W | Sticky per-channel status |
| wake_event | output | 1 | Combined wake request |

## Verification
The bench times a clear to land in the same cycle as a fresh edge detection. A design that let the clear win would lose that wake.

It also switches a channel to falling-edge mode in the same cycle that a falling transition leaves the synchronizer. A design without suppression would latch a spurious event there.

Status is sampled one cycle before and at the expected edge, which exposes a synchronizer with the wrong depth. Writes of all ones show whether the reserved and unimplemented positions leak control bits or status.

// File: rtl/wev_pkg.sv
package wev_pkg;
    typedef enum logic [1:0] {
        SEL_POL  = 2'd0,
        SEL_EDGE = 2'd1,
        SEL_EN   = 2'd2,
        SEL_NONE = 2'd3
    } wev_sel_e;
endpackage

// File: rtl/wev_sync.sv
module wev_sync #(
    parameter int          W    = 16,
    parameter logic [W-1:0] IDLE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] st1;
        logic [W-1:0] st2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d     = sync_q;
        sync_d.st1 = async_i;
        sync_d.st2 = sync_q.st1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.st1 <= IDLE;
            sync_q.st2 <= IDLE;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q.st2;
endmodule

// File: rtl/wev_regs.sv
module wev_regs
    import wev_pkg::*;
#(
    parameter int           W    = 16,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_sel,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] pol_o,
    output logic [W-1:0] edg_o,
    output logic [W-1:0] en_o,
    output logic [W-1:0] chg_o
);
    typedef struct packed {
        logic [W-1:0] pol;
        logic [W-1:0] edg;
        logic [W-1:0] en;
        logic [W-1:0] chg;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d     = regs_q;
        regs_d.chg = '0;
        if (wr_en) begin
            case (wev_sel_e'(wr_sel))
                SEL_POL:  regs_d.pol = wr_data & MASK;
                SEL_EDGE: regs_d.edg = wr_data & MASK;
                SEL_EN:   regs_d.en  = wr_data & MASK;
                default:  ;
            endcase
        end
        regs_d.chg = (regs_d.pol ^ regs_q.pol) | (regs_d.edg ^ regs_q.edg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (wev_sel_e'(rd_sel))
            SEL_POL:  rd_data = regs_q.pol;
            SEL_EDGE: rd_data = regs_q.edg;
            SEL_EN:   rd_data = regs_q.en;
            default:  rd_data = '0;
        endcase
    end

    assign pol_o = regs_q.pol;
    assign edg_o = regs_q.edg;
    assign en_o  = regs_q.en;
    assign chg_o = regs_q.chg;

    // R6: positions without a detector never hold control state
    assert_ctrl_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs_q.pol | regs_q.edg | regs_q.en) & ~MASK) == '0);
endmodule

// File: rtl/wev_chan.sv
module wev_chan #(
    parameter logic IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_i,
    input  logic pol_i,
    input  logic edg_i,
    input  logic chg_i,
    input  logic clr_i,
    output logic sts_o
);
    typedef struct packed {
        logic prev;
        logic sts;
    } chan_t;

    chan_t ch_d, ch_q;
    logic  active;
    logic  hit;

    always_comb begin
        active = (smp_i == pol_i);
        if (edg_i) hit = active && (ch_q.prev != smp_i) && !chg_i;
        else       hit = active;
        ch_d      = ch_q;
        ch_d.prev = smp_i;
        ch_d.sts  = hit | (ch_q.sts & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q.prev <= IDLE;
            ch_q.sts  <= 1'b0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign sts_o = ch_q.sts;

    // R9: a set status bit survives every cycle without a clear
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.sts && !clr_i) |=> ch_q.sts);

    // R10: a detection sets status even when a clear arrives with it
    assert_hit_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ch_q.sts);

    // R11: no edge event in the cycle following a mode change
    assert_mode_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_i && edg_i && !ch_q.sts) |=> !ch_q.sts);
endmodule

// File: rtl/wev_detect.sv
module wev_detect #(
    parameter int               CH_W      = 16,
    parameter logic [CH_W-1:0]  IMPL_MASK = 16'h17F0,
    parameter logic [CH_W-1:0]  IDLE_LVL  = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_W-1:0] wake_in,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [CH_W-1:0] wr_data,
    input  logic [1:0]      rd_sel,
    output logic [CH_W-1:0] rd_data,
    input  logic            clr_en,
    input  logic [CH_W-1:0] clr_mask,
    output logic [CH_W-1:0] status,
    output logic            wake_event
);
    logic [CH_W-1:0] smp;
    logic [CH_W-1:0] pol, edg, en, chg;
    logic [CH_W-1:0] clr_vec;
    logic [CH_W-1:0] sts;
    logic            unused_smp;

    assign clr_vec = clr_en ? clr_mask : '0;

    wev_sync #(.W(CH_W), .IDLE(IDLE_LVL)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(wake_in), .sync_o(smp)
    );

    wev_regs #(.W(CH_W), .MASK(IMPL_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .pol_o(pol), .edg_o(edg), .en_o(en), .chg_o(chg)
    );

    for (genvar i = 0; i < CH_W; i++) begin : g_ch
        if (IMPL_MASK[i]) begin : g_live
            wev_chan #(.IDLE(IDLE_LVL[i])) u_chan (
                .clk(clk), .rst_n(rst_n),
                .smp_i(smp[i]), .pol_i(pol[i]), .edg_i(edg[i]),
                .chg_i(chg[i]), .clr_i(clr_vec[i]), .sts_o(sts[i])
            );
        end else begin : g_void
            assign sts[i] = 1'b0;
        end
    end

    assign unused_smp = ^{smp & ~IMPL_MASK, pol & ~IMPL_MASK, edg & ~IMPL_MASK, chg & ~IMPL_MASK};

    assign status     = sts;
    assign wake_event = |(sts & en);
endmodule

// File: tb/sim_wev_detect.sv
module sim_wev_detect;
    localparam int CH_W = 16;
    localparam logic [CH_W-1:0] IMPL = 16'h17F0;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CH_W-1:0] wake_in = '1;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_sel = 2'd0;
    logic [CH_W-1:0] wr_data = '0;
    logic [1:0]      rd_sel = 2'd0;
    logic [CH_W-1:0] rd_data;
    logic            clr_en = 1'b0;
    logic [CH_W-1:0] clr_mask = '0;
    logic [CH_W-1:0] status;
    logic            wake_event;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wev_detect #(.CH_W(CH_W), .IMPL_MASK(IMPL)) u0 (
        .clk(clk), .rst_n(rst_n), .wake_in(wake_in),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .clr_en(clr_en), .clr_mask(clr_mask),
        .status(status), .wake_event(wake_event)
    );

    // vector: [8:5] channel, [4] polarity, [3] edge-select, [2] first level, [1] second level, [0] expected
    localparam int NV = 10;
    localparam logic [8:0] VEC [NV] = '{
        {4'd4,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R1 low level
        {4'd5,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1},  // R2 high level
        {4'd5,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 inactive level
        {4'd6,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1},  // R3 falling
        {4'd6,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R3 rising ignored
        {4'd7,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R4 rising
        {4'd7,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0},  // R4 falling ignored
        {4'd12, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R4 top channel
        {4'd11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R6 reserved slot
        {4'd8,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0}   // R3 steady input
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [CH_W-1:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic clr(input logic [CH_W-1:0] m);
        clr_en = 1'b1; clr_mask = m;
        cyc(1);
        clr_en = 1'b0; clr_mask = '0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [CH_W-1:0] v);
        rd_sel = sel;
        #0.1;
        v = rd_data;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [CH_W-1:0] v;
        cyc(3);
        // R5 reset state
        chk("R5 status", 32'(status), 32'h0);
        chk("R5 wake_event", 32'(wake_event), 32'h0);
        rd(2'd0, v); chk("R5 polarity", 32'(v), 32'h0);
        rd(2'd1, v); chk("R5 edge-select", 32'(v), 32'h0);
        rd(2'd2, v); chk("R5 enable", 32'(v), 32'h0);
        rst_n = 1'b1;
        cyc(2);

        // R6 readback mask
        wr(2'd0, '1); rd(2'd0, v); chk("R6 polarity mask", 32'(v), 32'(IMPL));
        wr(2'd1, '1); rd(2'd1, v); chk("R6 edge mask", 32'(v), 32'(IMPL));
        wr(2'd0, '0); wr(2'd1, '0);
        wr(2'd2, '1); rd(2'd2, v); chk("R6 enable mask", 32'(v), 32'(IMPL));
        cyc(4);
        clr('1);

        // vector table
        for (int i = 0; i < NV; i++) begin
            int ch;
            ch = int'(VEC[i][8:5]);
            wake_in = '1;
            wr(2'd0, VEC[i][4] ? (CH_W'(1) << ch) : '0);
            wr(2'd1, VEC[i][3] ? (CH_W'(1) << ch) : '0);
            wake_in[ch] = VEC[i][2];
            cyc(5);
            clr('1);
            cyc(1);
            wake_in[ch] = VEC[i][1];
            cyc(5);
            chk($sformatf("vector %0d status (R1 R2 R3 R4 R6)", i), 32'(status[ch]), 32'(VEC[i][0]));
            chk($sformatf("vector %0d wake_event R8", i), 32'(wake_event), 32'(VEC[i][0]));
        end
        wake_in = '1;
        wr(2'd0, '0); wr(2'd1, '0);
        cyc(3);
        clr('1);

        // R7 latency, channel 4 level low
        wake_in[4] = 1'b0;
        cyc(2);
        chk("R7 before third edge", 32'(status[4]), 32'h0);
        cyc(1);
        chk("R7 at third edge", 32'(status[4]), 32'h1);

        // R9 level re-sets while active
        clr('1);
        chk("R9 level holds through clear", 32'(status[4]), 32'h1);
        wake_in[4] = 1'b1;
        cyc(4);
        clr('1);
        chk("R9 level clears when inactive", 32'(status[4]), 32'h0);

        // R8 enable gating, channel 9
        wr(2'd2, ~(CH_W'(1) << 9));
        wake_in[9] = 1'b0;
        cyc(4);
        chk("R8 disabled status latches", 32'(status[9]), 32'h1);
        chk("R8 disabled no event", 32'(wake_event), 32'h0);
        wr(2'd2, '1);
        chk("R8 enabled event", 32'(wake_event), 32'h1);
        wake_in[9] = 1'b1;
        cyc(4);
        clr('1);

        // R9 edge sticky, channel 10 rising
        wr(2'd1, CH_W'(1) << 10);
        wr(2'd0, CH_W'(1) << 10);
        cyc(3);
        chk("R11 mode switch quiet", 32'(status[10]), 32'h0);
        wake_in[10] = 1'b0; cyc(4);
        wake_in[10] = 1'b1; cyc(4);
        chk("R4 rising latched", 32'(status[10]), 32'h1);
        cyc(10);
        chk("R9 edge status sticky", 32'(status[10]), 32'h1);
        clr(CH_W'(1) << 10);
        chk("R9 edge status cleared", 32'(status[10]), 32'h0);

        // R10 detection beats clear
        wake_in[10] = 1'b0; cyc(4);
        clr('1);
        wake_in[10] = 1'b1;
        cyc(2);
        clr_en = 1'b1; clr_mask = '1;
        cyc(1);
        clr_en = 1'b0; clr_mask = '0;
        chk("R10 detection wins", 32'(status[10]), 32'h1);
        clr('1);
        chk("R10 later clear works", 32'(status[10]), 32'h0);

        // R11 mode change coincides with a falling edge
        wake_in[10] = 1'b0;
        cyc(1);
        wr(2'd0, '0);
        cyc(3);
        chk("R11 edge suppressed", 32'(status[10]), 32'h0);
        wake_in[10] = 1'b1; cyc(4);
        wake_in[10] = 1'b0; cyc(4);
        chk("R3 falling after switch", 32'(status[10]), 32'h1);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule